// File: doc/BRIEF.md
# Mailbox Register Access Engine

This block sits on the controller side of a host mailbox. When the mailbox hands it a request, it latches the command byte, the sub-command, the size field and the outbound data buffer. It then checks that the request is a register-access message with a consistent size. After that it walks through the list of 16-bit register addresses packed into the buffer. For each entry it reads or writes an attached 8-bit register file, one access per clock.

Three operations are supported:

- A list read places the result bytes into a response buffer in list order.
- A list write takes its data bytes from the buffer, after the address bytes.
- A masked read-modify-write reads one register and rewrites it. Bits selected by a mask take the new value, and the other bits keep their old value.

Every request ends with a one-cycle done strobe. An error flag and an error code stay valid until the next request is accepted.

The engine is a single state machine with these states:

- `S_IDLE` waits for a request and moves to `S_CHECK` when `req_valid` is seen.
- `S_CHECK` moves to `S_FINISH` on a decode error. It moves to `S_RMW_RD` for a read-modify-write, and to `S_ACCESS` for a list read or write.
- `S_ACCESS` stays in place while list entries remain. It moves to `S_FINISH` after the last entry.
- `S_RMW_RD` always moves to `S_RMW_WR`, and `S_RMW_WR` always moves to `S_FINISH`.
- `S_FINISH` always moves back to `S_IDLE`.

Top module: `mbox_reg_engine`

## Requirements
- R1: During and after reset, `done`, `busy`, `err`, `rf_we` and `rf_re` are 0, `err_code` is 0 and `resp_buf` is all zeros.
- R2: The read operation uses command 0xFF, sub-command 1 and size 2N, with N from 1 to 5. Address i is taken from buffer bytes 2i (low) and 2i+1 (high). The reads are issued one per cycle in list order. Result i lands in response byte i, and all other response bytes are 0.
- R3: The write operation uses command 0xFF, sub-command 0 and size 3N, with N from 1 to 5. Data byte i is taken from buffer byte 2N+i. The writes are issued one per cycle in list order, so a repeated address ends holding the last data written to it.
- R4: The read-modify-write operation uses command 0xFF, sub-command 2 and size 4. The address is in bytes 0 and 1, the value in byte 2 and the mask in byte 3. The engine does one read cycle, then one write cycle of (old & ~mask) | (value & mask).
- R5: A command other than 0xFF gives error code 0x03. Otherwise, a sub-command above 2 gives code 0x01. Otherwise, a size that fits no count from 1 to 5 for that sub-command gives code 0x02. In each of these cases `err` is 1 and no register is read or written.
- R6: A valid request ends with `err` = 0 and `err_code` = 0.
- R7: `done` is high for exactly one cycle, in the cycle after the last access. Counting cycles after the edge that accepts the request, it arrives in cycle N+2 for a list read or write, cycle 4 for a read-modify-write and cycle 2 for an error.
- R8: `busy` is high from the cycle after acceptance up to and including the done cycle. A `req_valid` seen while busy is ignored.
- R9: `resp_buf`, `err` and `err_code` hold their values after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_cmd | input | 8 | Message command byte |
| req_sub | input | 4 | Sub-command |
| req_size | input | 8 | Size field in bytes |
| req_buf | input | OBUF_BYTES*8 | Outbound buffer, byte i at bits 8i+7:8i |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Error flag of the last request |
| err_code | output | 8 | Error code of the last request |
| resp_buf | output | RESP_BYTES*8 | Response buffer, byte i at bits 8i+7:8i |
| rf_addr | output | 16 | Register file address |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 8 | Register file write data |
| rf_re | output | 1 | Register file read strobe |
| rf_rdata | input | 8 | Register file read data, valid in the same cycle |

## Verification
Several corner cases are targeted directly:

- A write list that repeats an address checks the ordering. A design that issued the accesses out of order, or in parallel, would leave the wrong byte behind.
- Counts of one and five exercise both ends of the list walk. An off-by-one in the walk would drop the last entry or move `done` by one cycle.
- Read-modify-write with mixed masks catches an inverted mask or a lost old value.
- Sizes that are one off the expected formula, counts of six and zero, and unknown sub-commands and commands must each produce the right code with no access at all.
- A request pushed in while the engine is busy must leave the result untouched.

// File: rtl/mre_pkg.sv
package mre_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_ACCESS,
        S_RMW_RD,
        S_RMW_WR,
        S_FINISH
    } state_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RMW   = 2'd2
    } op_t;

    localparam logic [7:0] CMD_REG_ACCESS = 8'hFF;
    localparam logic [7:0] ERR_NONE       = 8'h00;
    localparam logic [7:0] ERR_SUB        = 8'h01;
    localparam logic [7:0] ERR_SIZE       = 8'h02;
    localparam logic [7:0] ERR_CMD        = 8'h03;
endpackage

// File: rtl/mre_decode.sv
module mre_decode
    import mre_pkg::*;
#(
    parameter int MAX_REGS = 5,
    parameter int CNT_W    = 3
) (
    input  logic [7:0]       cmd,
    input  logic [3:0]       sub,
    input  logic [7:0]       size,
    output logic             ok,
    output op_t              op,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       code
);
    logic sub_known;

    always_comb begin
        op        = OP_WRITE;
        count     = '0;
        sub_known = 1'b1;
        unique case (sub)
            4'd0: begin
                op = OP_WRITE;
                for (int k = 1; k <= MAX_REGS; k++)
                    if (size == 8'(3 * k)) count = CNT_W'(k);
            end
            4'd1: begin
                op = OP_READ;
                for (int k = 1; k <= MAX_REGS; k++)
                    if (size == 8'(2 * k)) count = CNT_W'(k);
            end
            4'd2: begin
                op = OP_RMW;
                if (size == 8'd4) count = CNT_W'(1);
            end
            default: sub_known = 1'b0;
        endcase

        ok   = 1'b0;
        code = ERR_NONE;
        if (cmd != CMD_REG_ACCESS)  code = ERR_CMD;
        else if (!sub_known)        code = ERR_SUB;
        else if (count == '0)       code = ERR_SIZE;
        else                        ok   = 1'b1;
    end
endmodule

// File: rtl/mre_resp.sv
module mre_resp #(
    parameter int BYTES = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         din,
    output logic [BYTES*8-1:0] flat
);
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)                        flat[g*8 +: 8] <= '0;
            else if (clr)                      flat[g*8 +: 8] <= '0;
            else if (we && idx == IDX_W'(g))   flat[g*8 +: 8] <= din;
        end
    end
endmodule

// File: rtl/mbox_reg_engine.sv
module mbox_reg_engine
    import mre_pkg::*;
#(
    parameter int MAX_REGS   = 5,
    parameter int OBUF_BYTES = 20,
    parameter int RESP_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [7:0]              req_cmd,
    input  logic [3:0]              req_sub,
    input  logic [7:0]              req_size,
    input  logic [OBUF_BYTES*8-1:0] req_buf,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [7:0]              err_code,
    output logic [RESP_BYTES*8-1:0] resp_buf,
    output logic [15:0]             rf_addr,
    output logic                    rf_we,
    output logic [7:0]              rf_wdata,
    output logic                    rf_re,
    input  logic [7:0]              rf_rdata
);
    localparam int CNT_W  = $clog2(MAX_REGS + 1);
    localparam int OIDX_W = $clog2(OBUF_BYTES);
    localparam int RIDX_W = $clog2(RESP_BYTES);

    state_t           state_q, state_d;
    op_t              op_q, dec_op;
    logic [CNT_W-1:0] idx_q, cnt_q, dec_count;
    logic [7:0]       cmd_q, size_q, old_q, dec_code;
    logic [3:0]       sub_q;
    logic [7:0]       obuf_q [OBUF_BYTES];
    logic             dec_ok, accept;
    logic [OIDX_W-1:0] lo_ix, hi_ix, wd_ix;

    mre_decode #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) u_decode (
        .cmd(cmd_q), .sub(sub_q), .size(size_q),
        .ok(dec_ok), .op(dec_op), .count(dec_count), .code(dec_code)
    );

    assign accept = (state_q == S_IDLE) && req_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_CHECK;
            S_CHECK:  state_d = !dec_ok ? S_FINISH :
                                (dec_op == OP_RMW) ? S_RMW_RD : S_ACCESS;
            S_ACCESS: if (idx_q == cnt_q - CNT_W'(1)) state_d = S_FINISH;
            S_RMW_RD: state_d = S_RMW_WR;
            S_RMW_WR: state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Request latch and walk counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0; sub_q <= '0; size_q <= '0;
            op_q <= OP_WRITE; cnt_q <= '0; idx_q <= '0; old_q <= '0;
            err <= 1'b0; err_code <= ERR_NONE;
            for (int i = 0; i < OBUF_BYTES; i++) obuf_q[i] <= '0;
        end else begin
            if (accept) begin
                cmd_q    <= req_cmd;
                sub_q    <= req_sub;
                size_q   <= req_size;
                err      <= 1'b0;
                err_code <= ERR_NONE;
                for (int i = 0; i < OBUF_BYTES; i++) obuf_q[i] <= req_buf[i*8 +: 8];
            end
            if (state_q == S_CHECK) begin
                op_q  <= dec_op;
                cnt_q <= dec_count;
                idx_q <= '0;
                if (!dec_ok) begin
                    err      <= 1'b1;
                    err_code <= dec_code;
                end
            end
            if (state_q == S_ACCESS) idx_q <= idx_q + CNT_W'(1);
            if (state_q == S_RMW_RD) old_q <= rf_rdata;
        end
    end

    // Outputs
    always_comb begin
        lo_ix    = OIDX_W'({idx_q, 1'b0});
        hi_ix    = lo_ix + OIDX_W'(1);
        wd_ix    = OIDX_W'({cnt_q, 1'b0}) + OIDX_W'(idx_q);
        rf_addr  = '0;
        rf_we    = 1'b0;
        rf_re    = 1'b0;
        rf_wdata = '0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_CHECK:  ;
            S_ACCESS: begin
                rf_addr  = {obuf_q[hi_ix], obuf_q[lo_ix]};
                rf_re    = (op_q == OP_READ);
                rf_we    = (op_q == OP_WRITE);
                rf_wdata = obuf_q[wd_ix];
            end
            S_RMW_RD: begin
                rf_addr = {obuf_q[1], obuf_q[0]};
                rf_re   = 1'b1;
            end
            S_RMW_WR: begin
                rf_addr  = {obuf_q[1], obuf_q[0]};
                rf_we    = 1'b1;
                rf_wdata = (old_q & ~obuf_q[3]) | (obuf_q[2] & obuf_q[3]);
            end
            S_FINISH: done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    mre_resp #(.BYTES(RESP_BYTES), .IDX_W(RIDX_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .clr(accept),
        .we(state_q == S_ACCESS && op_q == OP_READ),
        .idx(RIDX_W'(idx_q)), .din(rf_rdata), .flat(resp_buf)
    );

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> $past(rf_we || rf_re));
    p_no_touch_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && !dec_ok) |=> (!rf_we && !rf_re));
    p_rmw_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && op_q == OP_RMW) |-> $past(rf_re));
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(cmd_q));
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we && rf_re));
endmodule

// File: tb/mbox_reg_engine_bench.sv
module mbox_reg_engine_bench;
    localparam int OB = 20;
    localparam int RB = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_cmd = '0;
    logic [3:0] req_sub = '0;
    logic [7:0] req_size = '0;
    logic [OB*8-1:0] req_buf = '0;
    logic busy, done, err, rf_we, rf_re;
    logic [7:0] err_code, rf_wdata, rf_rdata;
    logic [RB*8-1:0] resp_buf;
    logic [15:0] rf_addr;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    mbox_reg_engine u_mbox_reg_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_sub(req_sub), .req_size(req_size), .req_buf(req_buf),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .resp_buf(resp_buf), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_rdata(rf_rdata)
    );

    function automatic logic [7:0] midx(input logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // Register file model and access log (single driver)
    logic [7:0]  mem [256];
    logic [15:0] log_addr [256];
    logic        log_we [256];
    int          log_total = 0;
    assign rf_rdata = mem[midx(rf_addr)];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        end else begin
            if (rf_we || rf_re) begin
                log_addr[log_total % 256] = rf_addr;
                log_we[log_total % 256]   = rf_we;
                log_total = log_total + 1;
            end
            if (rf_we) mem[midx(rf_addr)] = rf_wdata;
        end
    end

    logic [7:0]  exp_mem [256];
    logic [7:0]  ob [OB];
    logic [7:0]  exp_resp [RB];
    logic [15:0] exp_log_addr [8];
    logic        exp_log_we [8];
    int          exp_log_n;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic run(input logic [7:0] cmd, input logic [3:0] sub,
                       input logic [7:0] size, input int intr);
        int n, code, lat, k, base, bad;
        string tag;
        logic [15:0] a;
        logic [7:0] old, nv;
        logic [RB*8-1:0] saved;
        bit got;

        // Expected values from the requirements
        for (int i = 0; i < RB; i++) exp_resp[i] = 8'h00;
        exp_log_n = 0;
        n = 0;
        if (cmd != 8'hFF) code = 3;
        else if (sub > 4'd2) code = 1;
        else begin
            if (sub == 4'd0 && size % 3 == 0) n = size / 3;
            if (sub == 4'd1 && size % 2 == 0) n = size / 2;
            if (sub == 4'd2 && size == 8'd4) n = 1;
            if (n > 5) n = 0;
            code = (n == 0) ? 2 : 0;
        end
        if (code != 0) begin
            tag = "R5"; lat = 2;
        end else if (sub == 4'd1) begin
            tag = "R2"; lat = n + 2;
            for (int i = 0; i < n; i++) begin
                a = {ob[2*i+1], ob[2*i]};
                exp_resp[i] = exp_mem[midx(a)];
                exp_log_addr[i] = a; exp_log_we[i] = 1'b0;
            end
            exp_log_n = n;
        end else if (sub == 4'd0) begin
            tag = "R3"; lat = n + 2;
            for (int i = 0; i < n; i++) begin
                a = {ob[2*i+1], ob[2*i]};
                exp_mem[midx(a)] = ob[2*n+i];
                exp_log_addr[i] = a; exp_log_we[i] = 1'b1;
            end
            exp_log_n = n;
        end else begin
            tag = "R4"; lat = 4;
            a = {ob[1], ob[0]};
            old = exp_mem[midx(a)];
            nv = (old & ~ob[3]) | (ob[2] & ob[3]);
            exp_mem[midx(a)] = nv;
            exp_log_addr[0] = a; exp_log_we[0] = 1'b0;
            exp_log_addr[1] = a; exp_log_we[1] = 1'b1;
            exp_log_n = 2;
        end

        // Drive
        @(negedge clk);
        base = log_total;
        req_cmd = cmd; req_sub = sub; req_size = size;
        for (int i = 0; i < OB; i++) req_buf[i*8 +: 8] = ob[i];
        req_valid = 1'b1;
        @(posedge clk);
        k = 0; got = 1'b0;
        while (!got && k < 40) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                req_valid = 1'b0;
                chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
            end
            if (intr != 0 && k == intr) begin
                req_valid = 1'b1; req_cmd = 8'h00; req_sub = 4'd1; req_size = 8'd2;
            end else if (intr != 0 && k == intr + 1) req_valid = 1'b0;
            if (done) got = 1'b1;
        end
        req_valid = 1'b0;
        chk(k == lat, {tag, " R7 done latency"}, 32'(k), 32'(lat));
        chk(busy == 1'b1, "R8 busy in done cycle", 32'(busy), 1);
        chk(err == (code != 0) && err_code == 8'(code),
            (code != 0) ? "R5 error code" : "R6 no error",
            {23'd0, err, err_code}, {23'd0, code != 0, 8'(code)});
        bad = 0;
        for (int i = 0; i < RB; i++) if (resp_buf[i*8 +: 8] !== exp_resp[i]) bad++;
        chk(bad == 0, {tag, " R2 response bytes"}, 32'(bad), 0);
        chk(log_total - base == exp_log_n, {tag, " access count"},
            32'(log_total - base), 32'(exp_log_n));
        bad = 0;
        for (int i = 0; i < exp_log_n && i < log_total - base; i++)
            if (log_addr[(base+i) % 256] !== exp_log_addr[i] ||
                log_we[(base+i) % 256] !== exp_log_we[i]) bad++;
        chk(bad == 0, {tag, " access order"}, 32'(bad), 0);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
        chk(bad == 0, {tag, " R3 R4 register file contents"}, 32'(bad), 0);
        saved = resp_buf;
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", 32'(done), 0);
        repeat (2) @(negedge clk);
        chk(resp_buf == saved && err == (code != 0) && err_code == 8'(code),
            "R9 results held", {23'd0, err, err_code}, {23'd0, code != 0, 8'(code)});
    endtask

    task automatic set_addr(input int i, input logic [15:0] a);
        ob[2*i] = a[7:0]; ob[2*i+1] = a[15:8];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int n, s;
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        for (int i = 0; i < OB; i++) ob[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!done && !busy && !err && err_code == 0 && resp_buf == '0 && !rf_we && !rf_re,
            "R1 reset state", {28'd0, done, busy, err, rf_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!done && !busy && !err && resp_buf == '0, "R1 idle after reset",
            {29'd0, done, busy, err}, 0);

        // R2: read of one and of five
        set_addr(0, 16'h1234);
        run(8'hFF, 4'd1, 8'd2, 0);
        for (int i = 0; i < 5; i++) set_addr(i, 16'(16'h0100 * i + 16'h0037 + i));
        run(8'hFF, 4'd1, 8'd10, 0);
        // R3: write of five with a repeated address, last value wins
        set_addr(0, 16'h00A0); set_addr(1, 16'h00A1); set_addr(2, 16'h00A0);
        set_addr(3, 16'h0203); set_addr(4, 16'h00A0);
        ob[10] = 8'h11; ob[11] = 8'h22; ob[12] = 8'h33; ob[13] = 8'h44; ob[14] = 8'h55;
        run(8'hFF, 4'd0, 8'd15, 0);
        // R2 read back of the repeated address
        set_addr(0, 16'h00A0); set_addr(1, 16'h00A1);
        run(8'hFF, 4'd1, 8'd4, 0);
        // R4: masked update
        set_addr(0, 16'h00A0); ob[2] = 8'hF0; ob[3] = 8'h3C;
        run(8'hFF, 4'd2, 8'd4, 0);
        set_addr(0, 16'h7788); ob[2] = 8'hAA; ob[3] = 8'h00;
        run(8'hFF, 4'd2, 8'd4, 0);
        set_addr(0, 16'h7788); ob[2] = 8'h5A; ob[3] = 8'hFF;
        run(8'hFF, 4'd2, 8'd4, 0);
        // R5: error cases
        run(8'hFE, 4'd1, 8'd2, 0);
        run(8'hFF, 4'd3, 8'd2, 0);
        run(8'hFF, 4'd1, 8'd12, 0);
        run(8'hFF, 4'd1, 8'd0, 0);
        run(8'hFF, 4'd1, 8'd3, 0);
        run(8'hFF, 4'd0, 8'd4, 0);
        run(8'hFF, 4'd0, 8'd18, 0);
        run(8'hFF, 4'd2, 8'd3, 0);
        run(8'h00, 4'd7, 8'd99, 0);
        // R8: request pushed in while busy
        for (int i = 0; i < 5; i++) set_addr(i, 16'(16'h0A00 + 3 * i));
        run(8'hFF, 4'd1, 8'd10, 3);
        set_addr(0, 16'h0055); ob[2] = 8'h9C; ob[3] = 8'h00;
        run(8'hFF, 4'd0, 8'd3, 2);

        // Constrained random mix
        void'($urandom(32'd2718));
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < OB; i++) ob[i] = 8'($urandom);
            for (int i = 0; i < 5; i++)
                if ($urandom % 2 == 0) set_addr(i, 16'(16'h0300 + $urandom % 6));
            n = 1 + $urandom % 5;
            s = $urandom % 10;
            if (s < 4)      run(8'hFF, 4'd1, 8'(2 * n), 0);
            else if (s < 7) run(8'hFF, 4'd0, 8'(3 * n), 0);
            else if (s < 8) run(8'hFF, 4'd2, 8'd4, 0);
            else if (s < 9) run(8'hFF, 4'($urandom % 16), 8'($urandom % 20), 0);
            else            run(8'($urandom % 256), 4'd1, 8'd2, 0);
        end
        summary();
    end
endmodule